// File: doc/BRIEF.md
# Memory Module Socket Configuration Register Block

This block is a byte-wide I/O register file that sits beside the address decoder of a six-socket memory module controller. Board straps say which sockets hold a module and which of those modules are the large size. Software reads these straps back through two read-only ports. It then programs eight 5-bit bank end-address entries through one shared data port. The entries go straight to the address decoder. A per-socket enable flag tells the decoder which sockets map a non-empty range.

A write to the data port carries its own entry index in the upper data bits. A read of the data port returns the entry under a hidden readback pointer, which then advances and wraps. A read of the presence port sends that pointer back to zero, so software can walk all entries from a known start. A fourth port always reports that no parity error was seen. Each read is answered one clock later on a registered data bus with a valid pulse. The bus phase is a two-state machine: `PH_IDLE` moves to `PH_RESP` on a read strobe. `PH_RESP` stays in `PH_RESP` while reads continue back to back. Both states return to `PH_IDLE` when no read strobe is present.

Top module: `simm_cfg_regs`

## Requirements
- R1: A read of port 0x803 returns a byte whose bit n (n = 0..5) is 1 exactly when socket n is strapped present and strapped large; bits 7:6 are 0.
- R2: A read of port 0x804 returns a byte whose bit n (n = 0..5) is 0 when socket n is strapped present and 1 otherwise; bits 7:6 are 1.
- R3: Every read of port 0x804 sets the readback pointer to 0, so the next read of port 0x820 returns entry 0.
- R4: A write to port 0x820 stores write-data bits 4:0 into the entry whose index is write-data bits 7:5.
- R5: A read of port 0x820 returns the entry at the readback pointer in bits 4:0 with bits 7:5 zero. The pointer then advances by one and wraps from 7 to 0. Reads of other ports, except 0x804, leave the pointer unchanged.
- R6: A read of port 0x841 always returns 0x01.
- R7: Read data appears on the read-data bus with the valid flag high in the cycle after the read strobe is sampled. The valid flag is low in any cycle that follows a cycle with no read strobe.
- R8: After reset all eight entries, the readback pointer, the valid flag, the read data and all socket enable flags are 0.
- R9: Reads of any address other than the four mapped ports return 0x00. Writes to such addresses, and writes to ports 0x803, 0x804 and 0x841, change no entry.
- R10: The enable flag of socket s is 1 exactly when socket s is strapped present and entry s+1 differs from its start. The start is 0 for socket 0 and entry s otherwise.
- R11: The bank end output carries entry k in bits 5k+4 down to 5k, for k = 0..7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 12 | Port address of the access |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| bus_rvalid | output | 1 | High in the cycle after a read strobe |
| strap_present | input | 6 | Per-socket module present strap |
| strap_large | input | 6 | Per-socket large-module strap |
| bank_end | output | 40 | Eight 5-bit end-address entries, entry k at bits 5k+4:5k |
| slot_en | output | 6 | Per-socket enable flag for the address decoder |

## Verification
The assertions assume that the bus never raises the read and write strobes in the same cycle. They also assume the straps change only while no strobe is active, and that the address is stable whenever a strobe is high. The stimulus drives one strobe at a time from tasks on the falling edge. It holds the address with the strobe, and it changes the straps only in idle gaps between accesses. Back-to-back reads are issued so that the response state is also reached from itself.

// File: rtl/simm_cfg_pkg.sv
package simm_cfg_pkg;

    typedef enum logic [2:0] {
        PK_NONE,
        PK_ID,
        PK_PRES,
        PK_DATA,
        PK_PAR
    } port_kind_e;

    typedef enum logic {
        PH_IDLE,
        PH_RESP
    } bus_phase_e;

endpackage

// File: rtl/simm_port_decode.sv
module simm_port_decode
    import simm_cfg_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int ID_ADDR   = 'h803,
    parameter int PRES_ADDR = 'h804,
    parameter int DATA_ADDR = 'h820,
    parameter int PAR_ADDR  = 'h841
) (
    input  logic [ADDR_W-1:0] addr,
    output port_kind_e        kind
);

    always_comb begin
        if (addr == ADDR_W'(ID_ADDR))
            kind = PK_ID;
        else if (addr == ADDR_W'(PRES_ADDR))
            kind = PK_PRES;
        else if (addr == ADDR_W'(DATA_ADDR))
            kind = PK_DATA;
        else if (addr == ADDR_W'(PAR_ADDR))
            kind = PK_PAR;
        else
            kind = PK_NONE;
    end

endmodule

// File: rtl/simm_end_regs.sv
module simm_end_regs #(
    parameter int N_ENTRIES = 8,
    parameter int END_W     = 5,
    localparam int IDX_W    = $clog2(N_ENTRIES)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [IDX_W-1:0]           wr_idx,
    input  logic [END_W-1:0]           wr_val,
    input  logic                       rd_adv,
    input  logic                       ptr_clr,
    output logic [END_W-1:0]           rd_val,
    output logic [N_ENTRIES*END_W-1:0] ents_flat
);

    localparam logic [IDX_W-1:0] LAST = IDX_W'(N_ENTRIES - 1);

    logic [END_W-1:0] ents_q [N_ENTRIES];
    logic [IDX_W-1:0] ptr_q;

    for (genvar k = 0; k < N_ENTRIES; k++) begin : g_ent
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                ents_q[k] <= '0;
            else if (wr_en && wr_idx == IDX_W'(k))
                ents_q[k] <= wr_val;
        end
        assign ents_flat[k*END_W +: END_W] = ents_q[k];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            ptr_q <= '0;
        else if (ptr_clr)
            ptr_q <= '0;
        else if (rd_adv)
            ptr_q <= (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
    end

    assign rd_val = ents_q[ptr_q];

    // R3: a presence read returns the pointer to zero
    a_r3_ptr_clear: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_clr |=> ptr_q == '0);

    // R5: each data read advances the pointer once, wrapping at the last entry
    a_r5_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_adv && !ptr_clr && $past(rst_n)) |=>
            ptr_q == (($past(ptr_q) == LAST) ? '0 : $past(ptr_q) + 1'b1));

    // R5: the pointer holds when no read touches it
    a_r5_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_adv && !ptr_clr) |=> $stable(ptr_q));

    // R4: a write lands in the indexed entry
    a_r4_store: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> ents_q[$past(wr_idx)] == $past(wr_val));

    // R9: without a write strobe the entries do not move
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(ents_flat));

endmodule

// File: rtl/simm_slot_valid.sv
module simm_slot_valid #(
    parameter int N_SOCKETS = 6,
    parameter int N_ENTRIES = 8,
    parameter int END_W     = 5
) (
    input  logic [N_ENTRIES*END_W-1:0] ents_flat,
    input  logic [N_SOCKETS-1:0]       present,
    output logic [N_SOCKETS-1:0]       slot_en
);

    for (genvar s = 0; s < N_SOCKETS; s++) begin : g_slot
        logic [END_W-1:0] start_v;
        logic [END_W-1:0] end_v;
        if (s == 0) begin : g_first
            assign start_v = '0;
        end else begin : g_rest
            assign start_v = ents_flat[s*END_W +: END_W];
        end
        assign end_v      = ents_flat[(s+1)*END_W +: END_W];
        assign slot_en[s] = present[s] && (end_v != start_v);
    end

endmodule

// File: rtl/simm_cfg_regs.sv
module simm_cfg_regs
    import simm_cfg_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int DATA_W    = 8,
    parameter int N_SOCKETS = 6,
    parameter int N_ENTRIES = 8,
    parameter int END_W     = 5,
    parameter int ID_ADDR   = 'h803,
    parameter int PRES_ADDR = 'h804,
    parameter int DATA_ADDR = 'h820,
    parameter int PAR_ADDR  = 'h841
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [ADDR_W-1:0]          bus_addr,
    input  logic                       bus_rd,
    input  logic                       bus_wr,
    input  logic [DATA_W-1:0]          bus_wdata,
    output logic [DATA_W-1:0]          bus_rdata,
    output logic                       bus_rvalid,
    input  logic [N_SOCKETS-1:0]       strap_present,
    input  logic [N_SOCKETS-1:0]       strap_large,
    output logic [N_ENTRIES*END_W-1:0] bank_end,
    output logic [N_SOCKETS-1:0]       slot_en
);

    localparam int IDX_W = $clog2(N_ENTRIES);
    localparam logic [DATA_W-1:0] PAR_OK = DATA_W'(1);

    port_kind_e       kind;
    bus_phase_e       phase_q, phase_d;
    logic [DATA_W-1:0] rd_mux;
    logic [END_W-1:0] ent_rd;

    simm_port_decode #(
        .ADDR_W   (ADDR_W),
        .ID_ADDR  (ID_ADDR),
        .PRES_ADDR(PRES_ADDR),
        .DATA_ADDR(DATA_ADDR),
        .PAR_ADDR (PAR_ADDR)
    ) u_dec (
        .addr(bus_addr),
        .kind(kind)
    );

    simm_end_regs #(
        .N_ENTRIES(N_ENTRIES),
        .END_W    (END_W)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (bus_wr && kind == PK_DATA),
        .wr_idx   (bus_wdata[DATA_W-1 -: IDX_W]),
        .wr_val   (bus_wdata[END_W-1:0]),
        .rd_adv   (bus_rd && kind == PK_DATA),
        .ptr_clr  (bus_rd && kind == PK_PRES),
        .rd_val   (ent_rd),
        .ents_flat(bank_end)
    );

    simm_slot_valid #(
        .N_SOCKETS(N_SOCKETS),
        .N_ENTRIES(N_ENTRIES),
        .END_W    (END_W)
    ) u_slot (
        .ents_flat(bank_end),
        .present  (strap_present),
        .slot_en  (slot_en)
    );

    always_comb begin
        rd_mux = '0;
        unique case (kind)
            PK_ID:   rd_mux[N_SOCKETS-1:0] = strap_present & strap_large;
            PK_PRES: begin
                rd_mux = '1;
                rd_mux[N_SOCKETS-1:0] = ~strap_present;
            end
            PK_DATA: rd_mux[END_W-1:0] = ent_rd;
            PK_PAR:  rd_mux = PAR_OK;
            PK_NONE: rd_mux = '0;
        endcase
    end

    always_comb begin
        unique case (phase_q)
            PH_IDLE: phase_d = bus_rd ? PH_RESP : PH_IDLE;
            PH_RESP: phase_d = bus_rd ? PH_RESP : PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            phase_q <= PH_IDLE;
        else
            phase_q <= phase_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            bus_rdata <= '0;
        else if (bus_rd)
            bus_rdata <= rd_mux;
    end

    assign bus_rvalid = (phase_q == PH_RESP);

    // R7: a read strobe is answered in the next cycle
    a_r7_resp: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd |=> bus_rvalid);

    // R7: no response without a strobe in the previous cycle
    a_r7_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> !bus_rvalid);

    // R6: the parity port reads the fixed status
    a_r6_parity: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == ADDR_W'(PAR_ADDR)) |=> bus_rdata == PAR_OK);

    // R9: unmapped reads return zero
    a_r9_unmapped: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && kind == PK_NONE) |=> bus_rdata == '0);

    // R5: data-port read data never carries bits above the entry width
    a_r5_zero_ext: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && kind == PK_DATA) |=> bus_rdata[DATA_W-1:END_W] == '0);

    // R10: an absent socket is never enabled
    a_r10_absent: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_en & ~strap_present) == '0);

endmodule

// File: tb/simm_cfg_regs_bench.sv
module simm_cfg_regs_bench;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [11:0] bus_addr;
    logic        bus_rd;
    logic        bus_wr;
    logic [7:0]  bus_wdata;
    logic [7:0]  bus_rdata;
    logic        bus_rvalid;
    logic [5:0]  strap_present;
    logic [5:0]  strap_large;
    logic [39:0] bank_end;
    logic [5:0]  slot_en;

    int n_checks = 0;
    int n_fail   = 0;

    logic [7:0] q_exp[$];
    string      q_tag[$];
    logic [4:0] m_end [8];

    always #4 clk = ~clk;

    simm_cfg_regs u_simm_cfg_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .bus_addr     (bus_addr),
        .bus_rd       (bus_rd),
        .bus_wr       (bus_wr),
        .bus_wdata    (bus_wdata),
        .bus_rdata    (bus_rdata),
        .bus_rvalid   (bus_rvalid),
        .strap_present(strap_present),
        .strap_large  (strap_large),
        .bank_end     (bank_end),
        .slot_en      (slot_en)
    );

    task automatic check(input logic [63:0] got, input logic [63:0] exp, input string tag);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    function automatic logic [39:0] pack_ends();
        logic [39:0] v;
        for (int k = 0; k < 8; k++) v[k*5 +: 5] = m_end[k];
        return v;
    endfunction

    function automatic logic [5:0] exp_slots();
        logic [5:0] v;
        for (int s = 0; s < 6; s++)
            v[s] = strap_present[s] && (m_end[s+1] != ((s == 0) ? 5'd0 : m_end[s]));
        return v;
    endfunction

    // monitor: pops expected read data as responses appear
    always @(negedge clk) begin
        if (rst_n && bus_rvalid) begin
            if (q_exp.size() == 0) begin
                check(64'(bus_rdata), 64'hDEAD, "R7 unexpected response");
            end else begin
                logic [7:0] e;
                string t;
                e = q_exp.pop_front();
                t = q_tag.pop_front();
                check(64'(bus_rdata), 64'(e), t);
            end
        end
    end

    task automatic rd(input logic [11:0] a, input logic [7:0] e, input string tag);
        bus_addr = a;
        bus_rd   = 1'b1;
        q_exp.push_back(e);
        q_tag.push_back(tag);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic wr(input logic [11:0] a, input logic [7:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        if (a == 12'h820) m_end[d[7:5]] = d[4:0];
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] vals [8];
        vals = '{8'd3, 8'd4, 8'd8, 8'd8, 8'd12, 8'd12, 8'd20, 8'd31};
        for (int k = 0; k < 8; k++) m_end[k] = '0;
        rst_n = 1'b0; bus_rd = 1'b0; bus_wr = 1'b0;
        bus_addr = '0; bus_wdata = '0;
        strap_present = 6'b011011;
        strap_large   = 6'b001111;
        repeat (3) @(negedge clk);
        check(64'(bus_rvalid), 0, "R8 valid in reset");
        check(64'(bus_rdata), 0, "R8 rdata in reset");
        check(64'(bank_end), 0, "R8 entries in reset");
        check(64'(slot_en), 0, "R8 enables in reset");
        rst_n = 1'b1;
        @(negedge clk);
        rd(12'h820, 8'h00, "R8 entry0 after reset");

        rd(12'h803, 8'h0B, "R1 id pattern A");
        rd(12'h804, 8'hE4, "R2 presence pattern A");
        rd(12'h841, 8'h01, "R6 parity");
        rd(12'h900, 8'h00, "R9 unmapped read");
        rd(12'h802, 8'h00, "R9 neighbour read");
        @(negedge clk);
        check(64'(bus_rvalid), 0, "R7 valid low when idle");

        for (int k = 0; k < 8; k++) wr(12'h820, {3'(k), vals[k][4:0]});
        check(64'(bank_end), 64'(pack_ends()), "R11 R4 entries packed");
        check(64'(slot_en), 64'(exp_slots()), "R10 enables pattern A");
        check(64'(slot_en), 64'h0B, "R10 enables literal A");

        rd(12'h804, 8'hE4, "R3 presence before walk");
        for (int i = 0; i < 9; i++) rd(12'h820, {3'b0, m_end[i % 8]}, "R5 walk and wrap");
        rd(12'h820, {3'b0, m_end[1]}, "R5 after wrap");
        rd(12'h803, 8'h0B, "R1 id between data reads");
        rd(12'h841, 8'h01, "R6 parity between data reads");
        rd(12'h820, {3'b0, m_end[2]}, "R5 pointer kept over other ports");
        rd(12'h804, 8'hE4, "R3 presence clear");
        rd(12'h820, {3'b0, m_end[0]}, "R3 entry0 after clear");

        wr(12'h803, 8'hFF);
        wr(12'h804, 8'hE1);
        wr(12'h841, 8'h5E);
        wr(12'h7FF, 8'h3C);
        @(negedge clk);
        check(64'(bank_end), 64'(pack_ends()), "R9 ignored writes");
        check(64'(bank_end[4:0]), 64'd3, "R9 entry0 kept");

        wr(12'h820, 8'hA7);
        check(64'(bank_end[29:25]), 64'd7, "R4 entry5 from index field");
        check(64'(bank_end), 64'(pack_ends()), "R11 after overwrite");
        check(64'(slot_en), 64'(exp_slots()), "R10 after overwrite");

        strap_present = 6'b111111;
        strap_large   = 6'b110000;
        @(negedge clk);
        rd(12'h803, 8'h30, "R1 id pattern B");
        rd(12'h804, 8'hC0, "R2 presence pattern B");
        check(64'(slot_en), 64'h3B, "R10 enables pattern B");
        rd(12'h820, 8'h03, "R3 entry0 pattern B");
        repeat (3) @(negedge clk);
        check(64'(q_exp.size()), 0, "R7 all reads answered");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule